// File: doc/BRIEF.md
# Pseudo-Random Byte Generator with Selectable Seeding

This block is a deterministic pseudo-random source. A linear feedback shift register holds the internal state. Once the state is initialised, the register takes several feedback steps on every clock and presents one fresh byte each cycle. For a given starting state the sequence is always the same, so a test that uses it can be repeated exactly.

The state can be initialised in one of three ways, chosen on a mode input while reset is held. The first forces every state bit to one in the reset cycle. The second clears the state and then shifts ones in over a fixed number of cycles. The third shifts in a caller-supplied seed one bit per clock. A valid flag stays low until the chosen initialisation has finished, and the byte output reads zero while that flag is low. A seed of all zeros would lock the register, so the block replaces it with all ones.

Top module: `prng_byte_gen`

## Requirements
- R1: `initMode` is sampled on each clock edge where `rst` is high. 2'b00 selects the parallel set, 2'b01 the timed ones fill and 2'b10 the serial seed load. 2'b11 behaves exactly like 2'b00.
- R2: In parallel-set mode, `dataValid` is 1 and `dataOut` is 8'hFF in the first cycle after `rst` falls.
- R3: In fill mode, `dataValid` is 0 and `dataOut` is 8'h00 for the first FILL_CYCLES (6) clock edges after `rst` falls. After those edges the state is all ones, `dataValid` is 1 and `dataOut` is 8'hFF.
- R4: In seed mode, `seedIn` is captured on each of the STATE_W (16) clock edges after `rst` falls, most significant seed bit first. Afterwards `dataValid` is 1 and `dataOut` equals the low 8 bits of the seed.
- R5: If the seed shifted in is all zeros, the state becomes all ones and the first valid `dataOut` is 8'hFF.
- R6: While valid, each clock advances the 16-bit state by 8 steps. One step shifts the state left by one bit and puts the XOR of bits 15, 13, 12 and 10 into bit 0. `dataOut` is bits 7:0 of the state.
- R7: The output sequence repeats after exactly 2^16-1 clocks, and the state never becomes all zeros while valid.
- R8: `dataValid` stays high from the end of initialisation until the next reset. `dataOut` reads 8'h00 whenever `dataValid` is low.
- R9: A reset in the middle of a run restarts the identical sequence from the chosen initial state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| initMode | input | 2 | Initialisation choice, sampled during reset |
| seedIn | input | 1 | Serial seed bit, MSB first, used in seed mode |
| dataValid | output | 1 | High once initialisation is complete |
| dataOut | output | 8 | Pseudo-random byte, zero while not valid |

## Verification
The bench builds the block with its default 16-bit state, an 8-bit output and a six-cycle fill. With a 16-bit state the whole period of 65535 clocks is short enough to sweep, so every output in one full cycle of the sequence is compared against an arithmetic model, including the point where the sequence wraps. Several seeds cover the seed path: zero, a single low bit, a single high bit, all ones and a mixed pattern. Each mode encoding and a reset in the middle of a run are also exercised.

// File: rtl/prng_byte_pkg.sv
package prng_byte_pkg;

  typedef enum logic [1:0] {
    MODE_SET  = 2'b00,
    MODE_FILL = 2'b01,
    MODE_SEED = 2'b10,
    MODE_ALT  = 2'b11
  } initMode_e;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_FILL = 2'd1,
    PH_SEED = 2'd2
  } phase_e;

  typedef struct packed {
    logic loadOnes;
    logic loadZero;
    logic fillStep;
    logic seedStep;
    logic seedLast;
    logic run;
  } ctrlStrobe_t;

endpackage

// File: rtl/prng_byte_ctrl.sv
module prng_byte_ctrl
  import prng_byte_pkg::*;
#(
  parameter int STATE_W     = 16,
  parameter int FILL_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  initMode,
  output ctrlStrobe_t strobe,
  output logic        ready
);

  localparam int MAX_CNT = (STATE_W > FILL_CYCLES) ? STATE_W : FILL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(FILL_CYCLES - 1);
  localparam logic [CNT_W-1:0] SEED_LAST = CNT_W'(STATE_W - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             wantFill;
  logic             wantSeed;

  assign wantFill = (initMode == MODE_FILL);
  assign wantSeed = (initMode == MODE_SEED);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      if (wantFill)      phase <= PH_FILL;
      else if (wantSeed) phase <= PH_SEED;
      else               phase <= PH_RUN;
    end else begin
      case (phase)
        PH_FILL: begin
          if (cnt == FILL_LAST) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SEED: begin
          if (cnt == SEED_LAST) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (rst) begin
      strobe.loadOnes = !(wantFill || wantSeed);
      strobe.loadZero = wantFill || wantSeed;
    end else begin
      case (phase)
        PH_FILL: strobe.fillStep = 1'b1;
        PH_SEED: begin
          strobe.seedStep = 1'b1;
          strobe.seedLast = (cnt == SEED_LAST);
        end
        default: strobe.run = 1'b1;
      endcase
    end
  end

  assign ready = (phase == PH_RUN);

  // R3: the fill counter never runs past its window
  a_r3_fill_bounded: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FILL) |-> (cnt <= FILL_LAST));

  // R4: the seed counter never runs past the state width
  a_r4_seed_bounded: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SEED) |-> (cnt <= SEED_LAST));

  // R8: once ready, stays ready until reset
  a_r8_ready_holds: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

endmodule

// File: rtl/prng_byte_datapath.sv
module prng_byte_datapath
  import prng_byte_pkg::*;
#(
  parameter int               STATE_W     = 16,
  parameter int               OUT_W       = 8,
  parameter int               FILL_CYCLES = 6,
  parameter logic [STATE_W-1:0] TAPS      = 16'hB400
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        strobe,
  input  logic               seedIn,
  output logic [OUT_W-1:0]   word
);

  localparam int FILL_BITS = (STATE_W + FILL_CYCLES - 1) / FILL_CYCLES;
  localparam logic [STATE_W-1:0] FILL_MASK =
    (STATE_W'(1) << FILL_BITS) - STATE_W'(1);

  logic [STATE_W-1:0] state;
  logic [STATE_W-1:0] seedNext;
  logic [STATE_W-1:0] leapNext;

  function automatic logic [STATE_W-1:0] leap(input logic [STATE_W-1:0] s);
    logic [STATE_W-1:0] t;
    t = s;
    for (int i = 0; i < OUT_W; i++) begin
      t = {t[STATE_W-2:0], ^(t & TAPS)};
    end
    return t;
  endfunction

  always_comb begin
    seedNext = {state[STATE_W-2:0], seedIn};
    if (strobe.seedLast && (seedNext == '0)) seedNext = '1;
  end

  assign leapNext = leap(state);

  always_ff @(posedge clk) begin
    if (strobe.loadOnes)      state <= '1;
    else if (strobe.loadZero) state <= '0;
    else if (strobe.fillStep) state <= (state << FILL_BITS) | FILL_MASK;
    else if (strobe.seedStep) state <= seedNext;
    else if (strobe.run)      state <= leapNext;
  end

  assign word = state[OUT_W-1:0];

  // R7: the register never holds all zeros while running
  a_r7_never_zero: assert property (@(posedge clk) disable iff (rst)
    strobe.run |-> (state != '0));

  // R6: a running state always moves on
  a_r6_advances: assert property (@(posedge clk) disable iff (rst)
    strobe.run |=> (state != $past(state)));

  // R3: each fill step lands ones in the low bits
  a_r3_fill_ones: assert property (@(posedge clk) disable iff (rst)
    strobe.fillStep |=> (state[FILL_BITS-1:0] == '1));

  // R4: each non-final seed step captures the serial bit in bit 0
  a_r4_seed_capture: assert property (@(posedge clk) disable iff (rst)
    (strobe.seedStep && !strobe.seedLast) |=> (state[0] == $past(seedIn)));

  // R5: the final seed step never leaves a locked state
  a_r5_no_zero_seed: assert property (@(posedge clk) disable iff (rst)
    strobe.seedLast |=> (state != '0));

endmodule

// File: rtl/prng_byte_gen.sv
module prng_byte_gen
  import prng_byte_pkg::*;
#(
  parameter int                 STATE_W     = 16,
  parameter int                 OUT_W       = 8,
  parameter int                 FILL_CYCLES = 6,
  parameter logic [STATE_W-1:0] TAPS        = 16'hB400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       initMode,
  input  logic             seedIn,
  output logic             dataValid,
  output logic [OUT_W-1:0] dataOut
);

  ctrlStrobe_t        strobe;
  logic               ready;
  logic [OUT_W-1:0]   word;

  prng_byte_ctrl #(
    .STATE_W     (STATE_W),
    .FILL_CYCLES (FILL_CYCLES)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .initMode (initMode),
    .strobe   (strobe),
    .ready    (ready)
  );

  prng_byte_datapath #(
    .STATE_W     (STATE_W),
    .OUT_W       (OUT_W),
    .FILL_CYCLES (FILL_CYCLES),
    .TAPS        (TAPS)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .seedIn (seedIn),
    .word   (word)
  );

  assign dataValid = ready;
  assign dataOut   = ready ? word : '0;

endmodule

// File: tb/prng_byte_gen_tb.sv
module prng_byte_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] initMode = 2'b00;
  logic       seedIn = 1'b0;
  logic       dataValid;
  logic [7:0] dataOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  prng_byte_gen dut_i (
    .clk       (clk),
    .rst       (rst),
    .initMode  (initMode),
    .seedIn    (seedIn),
    .dataValid (dataValid),
    .dataOut   (dataOut)
  );

  // Model of R6: 8 left shifts, new bit 0 = s15^s13^s12^s10
  function automatic logic [15:0] model8(input logic [15:0] s);
    logic [15:0] t;
    t = s;
    for (int i = 0; i < 8; i++)
      t = {t[14:0], t[15] ^ t[13] ^ t[12] ^ t[10]};
    return t;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reset with the given mode; returns at the negedge after rst falls
  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1;
    initMode = m;
    @(negedge clk);
    rst = 1'b0;
    initMode = 2'b00;
  endtask

  task automatic seedLoad(input logic [15:0] seed, input string req);
    logic [15:0] exp;
    doReset(2'b10);
    for (int k = 0; k < 16; k++) begin
      check(req, {31'd0, dataValid}, 32'd0);
      seedIn = seed[15-k];
      @(negedge clk);
    end
    seedIn = 1'b0;
    exp = (seed == 16'h0) ? 16'hFFFF : seed;
    check(req, {31'd0, dataValid}, 32'd1);
    check(req, {24'd0, dataOut}, {24'd0, exp[7:0]});
    for (int k = 0; k < 20; k++) begin
      exp = model8(exp);
      @(negedge clk);
      check("R6 after seed", {23'd0, dataValid, dataOut}, {23'd0, 1'b1, exp[7:0]});
    end
  endtask

  initial begin
    logic [15:0] m;
    logic [7:0]  firstVals [0:3];

    // R2: parallel set
    doReset(2'b00);
    check("R2 valid", {31'd0, dataValid}, 32'd1);
    check("R2 first byte", {24'd0, dataOut}, 32'hFF);

    // R6 / R7: full-period sweep from all ones
    m = 16'hFFFF;
    for (int c = 1; c <= 65535; c++) begin
      m = model8(m);
      @(negedge clk);
      check("R6 sequence", {23'd0, dataValid, dataOut}, {23'd0, 1'b1, m[7:0]});
      if (c < 65535 && m == 16'hFFFF) begin
        fails++;
        checks++;
        $display("FAIL R7: model period short at %0d expected 65535", c);
      end
    end
    check("R7 wrap to start", {24'd0, dataOut}, 32'hFF);
    check("R7 model returns", {16'd0, m}, 32'h0000FFFF);

    // R1: mode 3 behaves as parallel set
    doReset(2'b11);
    check("R1 alt valid", {31'd0, dataValid}, 32'd1);
    check("R1 alt byte", {24'd0, dataOut}, 32'hFF);
    m = 16'hFFFF;
    for (int c = 0; c < 4; c++) begin
      m = model8(m);
      @(negedge clk);
      firstVals[c] = dataOut;
      check("R1 alt sequence", {24'd0, dataOut}, {24'd0, m[7:0]});
    end

    // R3: fill mode
    doReset(2'b01);
    for (int k = 0; k < 6; k++) begin
      check("R3 invalid during fill", {31'd0, dataValid}, 32'd0);
      check("R8 zero while invalid", {24'd0, dataOut}, 32'd0);
      @(negedge clk);
    end
    check("R3 valid after fill", {31'd0, dataValid}, 32'd1);
    check("R3 first byte", {24'd0, dataOut}, 32'hFF);
    m = 16'hFFFF;
    for (int k = 0; k < 10; k++) begin
      m = model8(m);
      @(negedge clk);
      check("R3 sequence", {24'd0, dataOut}, {24'd0, m[7:0]});
    end

    // R4 / R5: seed loads
    seedLoad(16'h0000, "R5 zero seed");
    seedLoad(16'h0001, "R4 seed 0001");
    seedLoad(16'h8000, "R4 seed 8000");
    seedLoad(16'hFFFF, "R4 seed FFFF");
    seedLoad(16'hACE1, "R4 seed ACE1");

    // R8: valid holds across a long run
    doReset(2'b00);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      check("R8 valid holds", {31'd0, dataValid}, 32'd1);
    end

    // R9: reset mid-run repeats the sequence
    doReset(2'b00);
    check("R9 restart byte", {24'd0, dataOut}, 32'hFF);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R9 repeat", {24'd0, dataOut}, {24'd0, firstVals[c]});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5 * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule